// File: doc/BRIEF.md
# Endian-Configurable Load/Store Byte-Lane Unit

This unit sits between a 32-bit core and a 32-bit, word-addressed data memory. For each request it forms an effective byte address from a base register and an offset. The offset is either a zero-extended immediate or an index register, and it is added to or subtracted from the base. The unit presents the word address to memory, and drives byte-enables and lane-steered write data for stores.

A runtime mode input chooses how byte addresses map onto the lanes of a word. In little-endian numbering, the byte at the lowest address sits in bits 7:0. In big-endian numbering, it sits in bits 31:24. Read data comes back from memory one cycle after the request. The unit then pulls out the addressed byte, halfword or word and returns it zero-extended or sign-extended.

Accesses that are not naturally aligned are reported on a flag and are not issued to memory. They are never split into smaller accesses.

Top module: `lsu_lane_unit`

## Requirements
- R1: The effective address is base + offset, or base − offset when `off_sub` is 1. The offset is the zero-extended `imm` when `use_imm` is 1 and `index` otherwise. For an issued access, `mem_waddr` equals effective address bits 31:2.
- R2: Size encoding is 00 byte, 01 halfword, 1x word. With `big_endian` = 0, a byte access at address offset a (address bits 1:0) enables only lane a, where lane k is bits 8k+7:8k.
- R3: With `big_endian` = 1, a byte access at address offset a enables only lane 3−a.
- R4: A halfword access enables the two lanes holding address bytes a and a+1 under the current numbering: lanes {0,1} or {2,3}.
- R5: An aligned word access enables all four lanes.
- R6: A store asserts `mem_wr` and not `mem_rd`. On every enabled lane, `mem_wdata` carries the store value's byte for that address. Little-endian puts the least significant byte at the lowest address; big-endian puts the most significant byte there. A byte store is replicated on all lanes and a halfword store on both halves.
- R7: A load asserts `mem_rd`. On the next cycle `ld_valid` is 1 and `ld_data` holds the addressed value assembled from that cycle's `mem_rdata`, with the same byte order as R6. Byte and halfword values are zero-extended when `req_signed` is 0. `ld_valid` is 0 in every cycle that does not follow an issued load.
- R8: With `req_signed` = 1, a byte load copies bit 7 into bits 31:8 and a halfword load copies bit 15 into bits 31:16.
- R9: A valid halfword request with address bit 0 set, or a valid word request with address bits 1:0 non-zero, raises `misaligned`. It drives `mem_be` to 0000, keeps `mem_rd` and `mem_wr` low, and produces no `ld_valid` on the next cycle.
- R10: While reset is asserted, `ld_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 1x word |
| req_signed | input | 1 | Sign-extend sub-word loads |
| big_endian | input | 1 | Lane numbering mode |
| use_imm | input | 1 | Offset from `imm` instead of `index` |
| off_sub | input | 1 | Subtract offset from base |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| imm | input | IMM_W | Unsigned immediate offset |
| st_data | input | 32 | Store value, right-justified |
| mem_rdata | input | 32 | Memory read word, one cycle after `mem_rd` |
| mem_waddr | output | 30 | Word address to memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered write data |
| misaligned | output | 1 | Request not naturally aligned, suppressed |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extended load result |

## Verification
Some properties are checked on every cycle by assertions:
- a suppressed access keeps its enables and strobes quiet;
- a byte access enables one lane, a halfword two adjacent lanes, and a word all four;
- read and write strobes never coincide;
- a load result appears only in the cycle after a read strobe;
- signed byte results carry bit 7 through the upper bits.

Which lane is chosen under each numbering mode, the address arithmetic, and the byte order of the steered and extracted data can only be shown by the bench's reference model. It recomputes every output from the address bytes under directed and random requests.

// File: rtl/lsu_lane_unit.sv
module lsu_lane_unit #(
  parameter int IMM_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_store,
  input  logic [1:0]       req_size,
  input  logic             req_signed,
  input  logic             big_endian,
  input  logic             use_imm,
  input  logic             off_sub,
  input  logic [31:0]      base,
  input  logic [31:0]      index,
  input  logic [IMM_W-1:0] imm,
  input  logic [31:0]      st_data,
  input  logic [31:0]      mem_rdata,
  output logic [29:0]      mem_waddr,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [3:0]       mem_be,
  output logic [31:0]      mem_wdata,
  output logic             misaligned,
  output logic             ld_valid,
  output logic [31:0]      ld_data
);
  logic [31:0] offset, eaddr;
  logic        is_word, is_half, bad_align, go;
  logic [1:0]  lane;
  logic [3:0]  be_raw;

  assign offset    = use_imm ? 32'(imm) : index;
  assign eaddr     = off_sub ? base - offset : base + offset;
  assign mem_waddr = eaddr[31:2];

  assign is_word   = req_size[1];
  assign is_half   = (req_size == 2'b01);
  assign bad_align = (is_word && eaddr[1:0] != 2'b00) || (is_half && eaddr[0]);
  assign misaligned = req_valid && bad_align;
  assign go        = req_valid && !bad_align;

  assign lane = big_endian ? ~eaddr[1:0] : eaddr[1:0];

  always_comb begin
    if (is_word)      be_raw = 4'hF;
    else if (is_half) be_raw = lane[1] ? 4'b1100 : 4'b0011;
    else              be_raw = 4'b0001 << lane;
  end

  assign mem_be = go ? be_raw : 4'b0000;
  assign mem_wr = go && req_store;
  assign mem_rd = go && !req_store;

  always_comb begin
    if (is_word)      mem_wdata = st_data;
    else if (is_half) mem_wdata = {2{st_data[15:0]}};
    else              mem_wdata = {4{st_data[7:0]}};
  end

  logic [1:0] r_lane, r_size;
  logic       r_signed;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ld_valid <= 1'b0;
      r_lane   <= 2'b00;
      r_size   <= 2'b00;
      r_signed <= 1'b0;
    end else begin
      ld_valid <= mem_rd;
      if (mem_rd) begin
        r_lane   <= lane;
        r_size   <= req_size;
        r_signed <= req_signed;
      end
    end
  end

  logic [7:0]  rd_byte;
  logic [15:0] rd_half;

  assign rd_byte = mem_rdata[{r_lane, 3'b000} +: 8];
  assign rd_half = r_lane[1] ? mem_rdata[31:16] : mem_rdata[15:0];

  always_comb begin
    if (r_size[1])           ld_data = mem_rdata;
    else if (r_size == 2'b01) ld_data = {{16{r_signed & rd_half[15]}}, rd_half};
    else                     ld_data = {{24{r_signed & rd_byte[7]}}, rd_byte};
  end
endmodule

module lsu_lane_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  req_size,
  input logic        req_signed,
  input logic        mem_rd,
  input logic        mem_wr,
  input logic [3:0]  mem_be,
  input logic        misaligned,
  input logic        ld_valid,
  input logic [31:0] ld_data
);
  // R9
  quiet_on_misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |-> (mem_be == 4'b0000 && !mem_rd && !mem_wr));
  // R2
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && req_size == 2'b00) |-> $countones(mem_be) == 1);
  // R4
  half_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && req_size == 2'b01) |-> (mem_be == 4'b0011 || mem_be == 4'b1100));
  // R5
  word_all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((mem_rd || mem_wr) && req_size[1]) |-> mem_be == 4'hF);
  // R6
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R7
  result_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> ld_valid);
  // R7
  no_stray_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_rd |=> !ld_valid);
  // R8
  signed_byte_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && $past(mem_rd && req_signed && req_size == 2'b00))
      |-> ld_data[31:8] == {24{ld_data[7]}});
endmodule

bind lsu_lane_unit lsu_lane_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_size(req_size), .req_signed(req_signed),
  .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_be(mem_be), .misaligned(misaligned),
  .ld_valid(ld_valid), .ld_data(ld_data)
);

// File: tb/test_lsu_lane_unit.sv
`timescale 1ns/1ps
module test_lsu_lane_unit;
  localparam int IMM_W = 12;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_store = 0, req_signed = 0, big_endian = 0, use_imm = 0, off_sub = 0;
  logic [1:0] req_size = 0;
  logic [31:0] base = 0, index = 0, st_data = 0, mem_rdata = 0;
  logic [IMM_W-1:0] imm = 0;
  logic [29:0] mem_waddr;
  logic mem_rd, mem_wr, misaligned, ld_valid;
  logic [3:0] mem_be;
  logic [31:0] mem_wdata, ld_data;

  int checks = 0, fails = 0;

  // p_* describe the load issued in the previous cycle
  bit p_valid = 0, p_signed = 0, p_be = 0;
  int p_off = 0, p_n = 0;

  always #4 clk = ~clk;

  lsu_lane_unit #(.IMM_W(IMM_W)) i_lsu_lane_unit (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int lane_of(int a, bit be);
    return be ? 3 - a : a;
  endfunction

  task automatic apply(bit v, bit st, logic [1:0] sz, bit sg, bit bend, bit ui, bit sb,
                       logic [31:0] b, logic [31:0] ix, logic [IMM_W-1:0] im,
                       logic [31:0] wd, logic [31:0] rd);
    logic [31:0] off, ea, ebe32, ewd, mask, val;
    int a, n;
    bit mis, issue;
    @(negedge clk);
    req_valid = v; req_store = st; req_size = sz; req_signed = sg; big_endian = bend;
    use_imm = ui; off_sub = sb; base = b; index = ix; imm = im; st_data = wd; mem_rdata = rd;
    #1;
    // result of the previous load
    chk("R7 ld_valid", {31'b0, ld_valid}, {31'b0, p_valid});
    if (p_valid) begin
      val = 0;
      for (int i = 0; i < p_n; i++) begin
        int sh = p_be ? 8 * (p_n - 1 - i) : 8 * i;
        val[sh +: 8] = rd[8 * lane_of(p_off + i, p_be) +: 8];
      end
      if (p_signed && p_n == 1 && val[7])  val[31:8]  = '1;
      if (p_signed && p_n == 2 && val[15]) val[31:16] = '1;
      chk(p_signed ? "R8 ld_data" : "R7 ld_data", ld_data, val);
    end
    // current request
    off = ui ? 32'(im) : ix;
    ea = sb ? b - off : b + off;
    a = int'(ea[1:0]);
    n = sz[1] ? 4 : (sz == 2'b01 ? 2 : 1);
    mis = v && ((n == 2 && a % 2 == 1) || (n == 4 && a != 0));
    issue = v && !mis;
    ebe32 = 0; ewd = 0; mask = 0;
    if (issue)
      for (int i = 0; i < n; i++) begin
        int ln = lane_of(a + i, bend);
        int sh = bend ? 8 * (n - 1 - i) : 8 * i;
        ebe32[ln] = 1'b1;
        mask[8*ln +: 8] = 8'hFF;
        ewd[8*ln +: 8] = wd[sh +: 8];
      end
    chk("R9 misaligned", {31'b0, misaligned}, {31'b0, mis});
    chk(n == 1 ? (bend ? "R3 mem_be" : "R2 mem_be") : (n == 2 ? "R4 mem_be" : "R5 mem_be"),
        {28'b0, mem_be}, ebe32);
    chk("R6 mem_wr", {31'b0, mem_wr}, {31'b0, issue && st});
    chk("R7 mem_rd", {31'b0, mem_rd}, {31'b0, issue && !st});
    if (issue) chk("R1 mem_waddr", {2'b0, mem_waddr}, {2'b0, ea[31:2]});
    if (issue && st) chk("R6 mem_wdata", mem_wdata & mask, ewd);
    p_valid = issue && !st; p_signed = sg; p_be = bend; p_off = a; p_n = n;
  endtask

  initial begin
    #(8ns * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 ld_valid in reset", {31'b0, ld_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R2 byte stores each lane LE, R3 BE
    for (int k = 0; k < 4; k++) apply(1, 1, 2'b00, 0, 0, 1, 0, 32'h1000, 0, 12'(k), 32'h000000A5 + k, 0);
    for (int k = 0; k < 4; k++) apply(1, 1, 2'b00, 0, 1, 1, 0, 32'h1000, 0, 12'(k), 32'h0000005A + k, 0);
    // R4 halfword stores both modes, R5 word
    apply(1, 1, 2'b01, 0, 0, 1, 0, 32'h2000, 0, 12'd2, 32'h0000BEEF, 0);
    apply(1, 1, 2'b01, 0, 1, 1, 0, 32'h2000, 0, 12'd0, 32'h0000CAFE, 0);
    apply(1, 1, 2'b10, 0, 1, 1, 0, 32'h2000, 0, 12'd4, 32'h11223344, 0);
    // R1 subtract index, add index
    apply(1, 0, 2'b10, 0, 0, 0, 1, 32'h3010, 32'h10, 0, 0, 0);
    apply(1, 0, 2'b00, 1, 0, 0, 0, 32'h3000, 32'h3, 0, 0, 32'h80FF7F01);
    // R8 signed byte/half, R7 zero-extended
    apply(1, 0, 2'b01, 1, 1, 1, 0, 32'h4000, 0, 12'd0, 0, 32'h8F000000);
    apply(1, 0, 2'b00, 0, 1, 1, 0, 32'h4000, 0, 12'd1, 0, 32'h9ABCDE80);
    apply(1, 0, 2'b10, 0, 0, 1, 0, 32'h4000, 0, 12'd0, 0, 32'hFF80C0E0);
    // R9 misaligned half and word, then idle
    apply(1, 0, 2'b01, 0, 0, 1, 0, 32'h5000, 0, 12'd1, 0, 32'h12345678);
    apply(1, 1, 2'b10, 0, 1, 1, 0, 32'h5000, 0, 12'd2, 32'hFFFFFFFF, 32'h12345678);
    apply(0, 0, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0, 32'hDEADBEEF);
    apply(0, 0, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0, 32'hDEADBEEF);
    for (int k = 0; k < 600; k++)
      apply($urandom_range(9) != 0, 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), $urandom, $urandom, IMM_W'($urandom),
            $urandom, $urandom);
    apply(0, 0, 2'b00, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule